// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received frame is accepted, looking only at its 48-bit destination address, which arrives already extracted from the frame and in parallel, with a single-cycle strobe. Addresses with the group bit set are looked up in a 512-entry table of single bits. The table index is built from a CRC-32 over the six address bytes. Individual addresses are accepted only when they match the programmed station address exactly. A promiscuous control input overrides both checks.

Software fills the table one entry per write. Each write carries a 9-bit entry index and a set/clear flag. The station address is loaded through two write strobes that share one 32-bit data bus. Every strobe yields one accept/reject verdict two clock cycles later.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset every table entry is 0, so a group address is rejected when no entry has been written and promiscuous mode is off. `verdict_vld` and `verdict_acc` are 0 while reset is held.
- R2: A table write on `tbl_wr` takes `tbl_wdata[8:0]` as the entry index and `tbl_wdata[9]` as the stored value, where 1 sets the entry and 0 clears it.
- R3: The table index for a group address is computed as follows. Run the reflected CRC-32 (polynomial 0xEDB88320, preset all ones, no final inversion) over address bytes 0..5 in that order, each byte least significant bit first. Bit-reverse the 32-bit result and take bits [31:23] of the reversed value. Byte k of the address is `dst_addr[8k+7:8k]`.
- R4: A group address (`dst_addr[0]` = 1) is accepted exactly when its table entry is 1 or promiscuous mode is on. An individual address is never accepted through the table.
- R5: An individual address is accepted when all 48 bits equal the station address. `stn_lo_wr` loads bytes 0..3 from `stn_wdata[31:0]`, with byte 0 in bits [7:0]. `stn_hi_wr` loads bytes 4 and 5 from `stn_wdata[15:0]`, with byte 4 in bits [7:0]. A difference in any single bit rejects.
- R6: While `promisc` is 1 in the strobe cycle, the verdict is accept for any address.
- R7: The broadcast address (all ones) is an ordinary group address and is decided by its table entry.
- R8: `verdict_vld` pulses exactly two clock cycles after each `addr_vld` cycle and at no other time. `verdict_acc` is 0 whenever `verdict_vld` is 0.
- R9: A table write in the same cycle as a strobe is not seen by that lookup, and is seen by the next one.
- R10: Clearing a previously set entry makes its group addresses rejected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_wr | input | 1 | Table write strobe |
| tbl_wdata | input | 10 | [8:0] entry index, [9] value |
| stn_lo_wr | input | 1 | Load station address bytes 0..3 |
| stn_hi_wr | input | 1 | Load station address bytes 4..5 |
| stn_wdata | input | 32 | Station address write data |
| promisc | input | 1 | Promiscuous enable |
| addr_vld | input | 1 | Destination address strobe |
| dst_addr | input | 48 | Destination address, byte k in [8k+7:8k] |
| verdict_vld | output | 1 | Verdict valid, two cycles after the strobe |
| verdict_acc | output | 1 | 1 = accept, 0 = reject |

## Verification
The assertions assume that `addr_vld` and `tbl_wr` are held low during reset, that the data buses are known whenever their strobes are high, and that `promisc` is stable around each strobe. The assertions relate strobes to verdicts through the internal stage flags, so back-to-back strobes are legal and the stimulus uses them. The bench drives every input one time unit after a rising edge and keeps all strobes low through reset. It varies the address patterns, including broadcast, single-bit station mismatches, and table writes placed in the same cycle as a lookup.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // Reflected CRC-32 over the address bytes, byte 0 first, LSB first.
  function automatic logic [31:0] crc_refl(input logic [ADDR_W-1:0] a);
    logic [31:0] r;
    logic        fb;
    r = 32'hFFFF_FFFF;
    for (int i = 0; i < ADDR_W; i++) begin
      fb = r[0] ^ a[i];
      r  = r >> 1;
      if (fb) r = r ^ CRC_POLY_REFL;
    end
    return r;
  endfunction

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] o;
    for (int i = 0; i < 32; i++) o[i] = v[31-i];
    return o;
  endfunction
endpackage

// File: rtl/mhf_index_gen.sv
module mhf_index_gen #(
  parameter int IDX_W = 9
) (
  input  logic [mhf_pkg::ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]           idx
);
  logic [31:0] crc_rev;
  always_comb begin
    crc_rev = mhf_pkg::rev32(mhf_pkg::crc_refl(addr));
    idx     = crc_rev[31 -: IDX_W];
  end
endmodule

// File: rtl/mhf_bit_table.sv
module mhf_bit_table #(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_val,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);
  localparam int DEPTH = 1 << IDX_W;
  logic [DEPTH-1:0] ent_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[g] <= 1'b0;
      else if (wr_en && (wr_idx == IDX_W'(g))) ent_q[g] <= wr_val;
    end
  end

  assign rd_bit = ent_q[rd_idx];

  // R2
  table_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ent_q[$past(wr_idx)] == $past(wr_val)));
endmodule

// File: rtl/mhf_station_match.sv
module mhf_station_match (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       lo_wr,
  input  logic                       hi_wr,
  input  logic [31:0]                wdata,
  input  logic [mhf_pkg::ADDR_W-1:0] addr,
  output logic                       hit
);
  localparam int HI_W = mhf_pkg::ADDR_W - 32;
  logic [31:0]     lo_q;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_wr) lo_q <= wdata;
      if (hi_wr) hi_q <= wdata[HI_W-1:0];
    end
  end

  assign hit = (addr == {hi_q, lo_q});
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int IDX_W = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tbl_wr,
  input  logic [9:0]  tbl_wdata,
  input  logic        stn_lo_wr,
  input  logic        stn_hi_wr,
  input  logic [31:0] stn_wdata,
  input  logic        promisc,
  input  logic        addr_vld,
  input  logic [47:0] dst_addr,
  output logic        verdict_vld,
  output logic        verdict_acc
);
  logic [IDX_W-1:0] look_idx;
  logic             look_bit;
  logic             stn_hit;
  logic             is_group;

  logic s1_vld, s1_prom, s1_grp, s1_stn, s1_hbit;

  assign is_group = dst_addr[0];

  mhf_index_gen #(.IDX_W(IDX_W)) u_idx (
    .addr (dst_addr),
    .idx  (look_idx)
  );

  mhf_bit_table #(.IDX_W(IDX_W)) u_tbl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (tbl_wr),
    .wr_idx (tbl_wdata[IDX_W-1:0]),
    .wr_val (tbl_wdata[IDX_W]),
    .rd_idx (look_idx),
    .rd_bit (look_bit)
  );

  mhf_station_match u_stn (
    .clk   (clk),
    .rst_n (rst_n),
    .lo_wr (stn_lo_wr),
    .hi_wr (stn_hi_wr),
    .wdata (stn_wdata),
    .addr  (dst_addr),
    .hit   (stn_hit)
  );

  // Stage 1: table read with pre-write contents, station compare.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_prom <= 1'b0;
      s1_grp  <= 1'b0;
      s1_stn  <= 1'b0;
      s1_hbit <= 1'b0;
    end else begin
      s1_vld <= addr_vld;
      if (addr_vld) begin
        s1_prom <= promisc;
        s1_grp  <= is_group;
        s1_stn  <= stn_hit;
        s1_hbit <= look_bit;
      end
    end
  end

  // Stage 2: verdict.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_vld <= 1'b0;
      verdict_acc <= 1'b0;
    end else begin
      verdict_vld <= s1_vld;
      verdict_acc <= s1_vld & (s1_prom | (s1_grp ? s1_hbit : s1_stn));
    end
  end

  // R8
  strobe_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |=> s1_vld);
  // R8
  verdict_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> verdict_vld);
  // R8
  no_spurious_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> !verdict_vld);
  // R8
  acc_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_vld |-> !verdict_acc);
  // R6
  promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s1_prom) |=> verdict_acc);
  // R4
  indiv_no_hash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && !s1_grp && !s1_prom && !s1_stn) |=> !verdict_acc);
endmodule

// File: tb/mcast_hash_filter_test.sv
module mcast_hash_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_wr = 1'b0;
  logic [9:0]  tbl_wdata = '0;
  logic        stn_lo_wr = 1'b0;
  logic        stn_hi_wr = 1'b0;
  logic [31:0] stn_wdata = '0;
  logic        promisc = 1'b0;
  logic        addr_vld = 1'b0;
  logic [47:0] dst_addr = '0;
  logic        verdict_vld;
  logic        verdict_acc;

  always #2 clk = ~clk;

  mcast_hash_filter uut (.*);

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  bit          m_tbl [512];
  logic [47:0] m_stn = '0;

  bit    q_acc [$];
  int    q_cyc [$];
  string q_tag [$];

  always @(posedge clk) cyc <= cyc + 1;

  // Non-reflected form: its register equals the reversed reflected one.
  function automatic logic [8:0] ref_idx(input logic [47:0] a);
    logic [31:0] s;
    logic        fb;
    s = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++)
      for (int j = 0; j < 8; j++) begin
        fb = s[31] ^ a[8*k+j];
        s = {s[30:0], 1'b0};
        if (fb) s = s ^ 32'h04C11DB7;
      end
    return s[31:23];
  endfunction

  function automatic bit predict(input logic [47:0] a, input bit p);
    if (p) return 1'b1;
    if (a[0]) return m_tbl[ref_idx(a)];
    return a == m_stn;
  endfunction

  task automatic note(input bit ok, input string tag, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic lookup(input logic [47:0] a, input bit p, input string tag);
    @(posedge clk); #1;
    q_acc.push_back(predict(a, p));
    q_cyc.push_back(cyc + 2);
    q_tag.push_back(tag);
    addr_vld = 1'b1; dst_addr = a; promisc = p;
    @(posedge clk); #1;
    addr_vld = 1'b0; promisc = 1'b0;
  endtask

  task automatic twrite(input logic [8:0] idx, input bit v);
    @(posedge clk); #1;
    tbl_wr = 1'b1; tbl_wdata = {v, idx};
    @(posedge clk); #1;
    tbl_wr = 1'b0;
    m_tbl[idx] = v;
  endtask

  // R9: write and lookup in the same cycle; expectation uses old table.
  task automatic lookup_with_write(input logic [47:0] a, input logic [8:0] idx, input bit v);
    @(posedge clk); #1;
    q_acc.push_back(predict(a, 1'b0));
    q_cyc.push_back(cyc + 2);
    q_tag.push_back("R9 same-cycle");
    addr_vld = 1'b1; dst_addr = a; promisc = 1'b0;
    tbl_wr = 1'b1; tbl_wdata = {v, idx};
    @(posedge clk); #1;
    addr_vld = 1'b0; tbl_wr = 1'b0;
    m_tbl[idx] = v;
  endtask

  task automatic set_station(input logic [47:0] a);
    @(posedge clk); #1;
    stn_lo_wr = 1'b1; stn_wdata = a[31:0];
    @(posedge clk); #1;
    stn_lo_wr = 1'b0; stn_hi_wr = 1'b1; stn_wdata = {16'h0, a[47:32]};
    @(posedge clk); #1;
    stn_hi_wr = 1'b0;
    m_stn = a;
  endtask

  // Monitor: pops expectations as verdicts appear.
  always @(negedge clk) begin
    if (rst_n && verdict_vld) begin
      if (q_acc.size() == 0) note(1'b0, "R8", "verdict with no pending lookup");
      else begin
        bit e; int c; string t;
        e = q_acc.pop_front(); c = q_cyc.pop_front(); t = q_tag.pop_front();
        note(c == cyc, "R8", $sformatf("%s cycle act=%0d exp=%0d", t, cyc, c));
        note(verdict_acc == e, t, $sformatf("accept act=%0b exp=%0b", verdict_acc, e));
      end
    end else if (rst_n && verdict_acc) begin
      note(1'b0, "R8", "accept without valid act=1 exp=0");
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      note(1'b0, "watchdog", "timeout act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] g1, g2, u1, bc;
    logic [8:0]  i1;
    for (int i = 0; i < 512; i++) m_tbl[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    note(verdict_vld == 1'b0 && verdict_acc == 1'b0, "R1",
         $sformatf("reset outputs act=%0b%0b exp=00", verdict_vld, verdict_acc));
    rst_n = 1'b1;

    g1 = 48'h5E_00_00_00_00_01 | 48'h1;
    g2 = 48'h22_33_44_55_66_03;
    u1 = 48'hAB_89_67_45_23_00;
    bc = 48'hFFFF_FFFF_FFFF;

    lookup(g1, 0, "R1 empty table");
    lookup(bc, 0, "R7 broadcast empty");

    i1 = ref_idx(g1);
    twrite(i1, 1'b1);
    lookup(g1, 0, "R3 hash hit");
    lookup(g2, 0, "R3 other group");
    twrite(ref_idx(g2) ^ 9'h1, 1'b1);
    lookup(g2, 0, "R2 neighbor entry");
    twrite(ref_idx(g2), 1'b1);
    lookup(g2, 0, "R2 set entry");

    twrite(ref_idx(u1 | 48'h1), 1'b1);
    twrite(ref_idx(u1), 1'b1);
    lookup(u1, 0, "R4 unicast via hash");

    set_station(u1);
    lookup(u1, 0, "R5 station hit");
    for (int b = 0; b < 48; b += 7)
      lookup(u1 ^ (48'h2 << b), 0, "R5 one-bit miss");

    lookup(48'h0000_0000_0002, 1, "R6 promisc unicast");
    lookup(g1 ^ 48'h100, 1, "R6 promisc group");

    twrite(ref_idx(bc), 1'b1);
    lookup(bc, 0, "R7 broadcast set");

    twrite(i1, 1'b0);
    lookup(g1, 0, "R10 cleared");

    lookup_with_write(g1, i1, 1'b1);
    lookup(g1, 0, "R9 next lookup");

    // back-to-back strobes
    @(posedge clk); #1;
    q_acc.push_back(predict(g1, 0)); q_cyc.push_back(cyc + 2); q_tag.push_back("R8 b2b a");
    addr_vld = 1'b1; dst_addr = g1;
    @(posedge clk); #1;
    q_acc.push_back(predict(u1, 0)); q_cyc.push_back(cyc + 2); q_tag.push_back("R8 b2b b");
    dst_addr = u1;
    @(posedge clk); #1;
    addr_vld = 1'b0;

    repeat (6) @(posedge clk);
    note(q_acc.size() == 0, "R8", $sformatf("pending act=%0d exp=0", q_acc.size()));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule